// File: doc/BRIEF.md
# Flash Program/Erase Protection Guard

This block decides whether the flash sequencer may start or continue a program or erase operation. Software sets three things through a small register port: an unlock key, a routine-load enable bit and a RAM-emulation enable bit. Permission is granted only when the key matches a fixed parameter value, the load enable is set and emulation is off. When any one of these is not in its permitting state, the block stays protected.

While the sequencer reports busy, the guard watches four event strobes: an interrupt request (maskable or not), a read of the flash array (data, vector or instruction fetch), entry into sleep or standby, and a bus grant to a master other than the CPU. Any of them latches a sticky error flag. In the same cycle the guard pulses an abort output and withdraws permission. Only reset clears the flag. Events that arrive while the sequencer is idle are ignored.

Top module: `flash_pe_guard`

## Requirements
- R1: After reset the key register reads 0x00, the control register reads 0x00, the error flag is 0, `permit` is 0 and `abort` is 0.
- R2: `permit` is 1 exactly when the key register equals KEY (default 0xA5), control bit 0 (load enable) is 1, control bit 1 (emulation enable) is 0, the error flag is 0, and no error is being detected in the current cycle.
- R3: Any key value other than KEY keeps `permit` at 0.
- R4: With load enable at 0, `permit` is 0.
- R5: With emulation enable at 1, `permit` is 0.
- R6: In a cycle where `busy` is 1, the error flag is 0 and any of `ev_irq`, `ev_array_rd`, `ev_sleep` or `ev_ext_master` is 1, `abort` is 1 and `permit` is 0 in that cycle. The error flag reads 1 from the next cycle on.
- R7: `abort` is a single-cycle pulse. Once the error flag is set, `abort` stays 0.
- R8: The error flag is sticky. Register writes cannot clear it, and `permit` stays 0 until reset.
- R9: Event strobes while `busy` is 0 leave the error flag at 0 and do not affect `permit` or `abort`.
- R10: Register map. Address 0 is the 8-bit key (read/write). Address 1 is control: bit 0 is load enable (read/write), bit 1 is emulation enable (read/write), bit 7 is the error flag (read-only) and the other bits read 0. Addresses 2 and 3 read 0 and ignore writes. Writes take effect on the clock edge. `reg_rdata` is combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW (8) | Write data |
| reg_rdata | output | DW (8) | Read data for `reg_addr` |
| busy | input | 1 | Program/erase in progress, from the sequencer |
| ev_irq | input | 1 | Interrupt request, including non-maskable |
| ev_array_rd | input | 1 | Flash array read, vector fetch or instruction fetch |
| ev_sleep | input | 1 | Sleep or standby entry |
| ev_ext_master | input | 1 | Bus granted to a non-CPU master |
| abort | output | 1 | One-cycle abort pulse on error detection |
| permit | output | 1 | Program/erase allowed |

## Verification
Four behaviours are checked by the assertions on every cycle:
- `permit` never rises unless key, load enable, emulation bit and error flag all allow it.
- Abort is a one-cycle pulse that occurs only while busy, and it excludes permission.
- A busy-time event always sets the error flag, and the flag never falls outside reset.
- Idle-time events never set the error flag.

Other behaviours can only be shown by the bench's scenarios. These are the exact register read-back layout, the refusal of each wrong key and each control combination, and the fact that a write to the control register cannot clear the flag. The bench also drives each of the four event kinds separately and mixes random traffic that includes periodic resets.

// File: rtl/flash_pe_guard.sv
module flash_pe_guard #(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy,
  input  logic          ev_irq,
  input  logic          ev_array_rd,
  input  logic          ev_sleep,
  input  logic          ev_ext_master,
  output logic          abort,
  output logic          permit
);
  localparam logic [1:0] A_KEY  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;

  logic [DW-1:0] key_q;
  logic          ld_en_q, emu_q, err_q;
  logic          any_ev, err_now, unlocked;

  assign any_ev   = ev_irq | ev_array_rd | ev_sleep | ev_ext_master;
  assign err_now  = busy & any_ev & ~err_q;
  assign unlocked = (key_q == KEY) & ld_en_q & ~emu_q;
  assign abort    = err_now;
  assign permit   = unlocked & ~err_q & ~err_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q   <= '0;
      ld_en_q <= 1'b0;
      emu_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_KEY) key_q <= reg_wdata;
      if (reg_wr && reg_addr == A_CTRL) begin
        ld_en_q <= reg_wdata[0];
        emu_q   <= reg_wdata[1];
      end
      if (err_now) err_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_KEY:  reg_rdata = key_q;
      A_CTRL: begin
        reg_rdata[0]    = ld_en_q;
        reg_rdata[1]    = emu_q;
        reg_rdata[DW-1] = err_q;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

module flash_pe_guard_chk #(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY = 8'hA5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          ev_irq,
  input logic          ev_array_rd,
  input logic          ev_sleep,
  input logic          ev_ext_master,
  input logic          abort,
  input logic          permit,
  input logic [DW-1:0] key_q,
  input logic          ld_en_q,
  input logic          emu_q,
  input logic          err_q
);
  logic ev;
  assign ev = ev_irq | ev_array_rd | ev_sleep | ev_ext_master;

  p_permit_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> (key_q == KEY && ld_en_q && !emu_q && !err_q));
  p_abort_no_permit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!permit && busy));
  p_err_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ev && !err_q) |=> err_q);
  p_abort_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_idle_events_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !err_q) |=> !err_q);
endmodule

bind flash_pe_guard flash_pe_guard_chk #(.DW(DW), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .ev_irq(ev_irq), .ev_array_rd(ev_array_rd), .ev_sleep(ev_sleep),
  .ev_ext_master(ev_ext_master), .abort(abort), .permit(permit),
  .key_q(key_q), .ld_en_q(ld_en_q), .emu_q(emu_q), .err_q(err_q)
);

// File: tb/tb_flash_pe_guard.sv
`timescale 1ns/1ps
module tb_flash_pe_guard;
  localparam logic [7:0] KEYV = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic busy = 1'b0, ev_irq = 1'b0, ev_array_rd = 1'b0, ev_sleep = 1'b0, ev_ext_master = 1'b0;
  logic abort, permit;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] m_key;
  logic m_ld, m_emu, m_err;

  always #2 clk = ~clk;

  flash_pe_guard dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .ev_irq(ev_irq), .ev_array_rd(ev_array_rd), .ev_sleep(ev_sleep),
    .ev_ext_master(ev_ext_master), .abort(abort), .permit(permit));

  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_key;
      2'd1: return {m_err, 5'd0, m_emu, m_ld};
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic exp_abort(input logic b, input logic [3:0] ev);
    return b & (|ev) & ~m_err;
  endfunction

  function automatic logic exp_permit(input logic b, input logic [3:0] ev);
    return (m_key == KEYV) & m_ld & ~m_emu & ~m_err & ~exp_abort(b, ev);
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [7:0] d,
                      input logic b, input logic [3:0] ev, input string tag);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; busy = b;
    {ev_irq, ev_array_rd, ev_sleep, ev_ext_master} = ev;
    #1;
    chk(tag, "permit", {7'd0, permit}, {7'd0, exp_permit(b, ev)});
    chk(tag, "abort", {7'd0, abort}, {7'd0, exp_abort(b, ev)});
    chk(tag, "rdata", reg_rdata, exp_rd(a));
    @(posedge clk);
    if (exp_abort(b, ev)) m_err = 1'b1;
    if (wr && a == 2'd0) m_key = d;
    if (wr && a == 2'd1) begin m_ld = d[0]; m_emu = d[1]; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; busy = 1'b0;
    {ev_irq, ev_array_rd, ev_sleep, ev_ext_master} = 4'd0;
    m_key = 8'd0; m_ld = 1'b0; m_emu = 1'b0; m_err = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic unlock();
    step(1'b1, 2'd0, KEYV, 1'b0, 4'd0, "R2");
    step(1'b1, 2'd1, 8'h01, 1'b0, 4'd0, "R2");
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    step(1'b0, 2'd0, 8'h00, 1'b0, 4'd0, "R1");
    step(1'b0, 2'd1, 8'h00, 1'b0, 4'd0, "R1");
    unlock();
    step(1'b0, 2'd1, 8'h00, 1'b0, 4'd0, "R2");
    // R3 wrong keys
    step(1'b1, 2'd0, 8'h5A, 1'b0, 4'd0, "R3");
    step(1'b0, 2'd0, 8'h00, 1'b0, 4'd0, "R3");
    step(1'b1, 2'd0, 8'hA4, 1'b0, 4'd0, "R3");
    step(1'b1, 2'd0, KEYV, 1'b0, 4'd0, "R3");
    // R4 / R5 control combinations
    step(1'b1, 2'd1, 8'h00, 1'b0, 4'd0, "R4");
    step(1'b1, 2'd1, 8'h03, 1'b0, 4'd0, "R4");
    step(1'b1, 2'd1, 8'h02, 1'b0, 4'd0, "R5");
    step(1'b1, 2'd1, 8'hFD, 1'b0, 4'd0, "R5");
    step(1'b0, 2'd1, 8'h00, 1'b0, 4'd0, "R10");
    // R10 unused addresses
    step(1'b1, 2'd2, 8'hFF, 1'b0, 4'd0, "R10");
    step(1'b1, 2'd3, 8'hFF, 1'b0, 4'd0, "R10");
    step(1'b0, 2'd0, 8'h00, 1'b0, 4'd0, "R10");
    // R9 idle events
    for (int e = 0; e < 4; e++) step(1'b0, 2'd1, 8'h00, 1'b0, 4'(1 << e), "R9");
    step(1'b0, 2'd1, 8'h00, 1'b0, 4'hF, "R9");
    step(1'b0, 2'd1, 8'h00, 1'b1, 4'd0, "R9");
    // R6 / R7 / R8 each event separately
    for (int e = 0; e < 4; e++) begin
      do_reset();
      unlock();
      step(1'b0, 2'd1, 8'h00, 1'b1, 4'd0, "R6");
      step(1'b0, 2'd1, 8'h00, 1'b1, 4'(1 << e), "R6");
      step(1'b0, 2'd1, 8'h00, 1'b1, 4'(1 << e), "R7");
      step(1'b1, 2'd1, 8'h01, 1'b0, 4'd0, "R8");
      step(1'b1, 2'd1, 8'h00, 1'b0, 4'd0, "R8");
      step(1'b1, 2'd1, 8'h81, 1'b0, 4'd0, "R8");
      step(1'b1, 2'd0, KEYV, 1'b0, 4'd0, "R8");
      step(1'b0, 2'd1, 8'h00, 1'b0, 4'd0, "R8");
    end
    // constrained random with periodic resets
    for (int blk = 0; blk < 20; blk++) begin
      do_reset();
      step(1'b0, 2'd1, 8'h00, 1'b0, 4'd0, "R1");
      for (int i = 0; i < 150; i++) begin
        logic wr;
        logic [1:0] a;
        logic [7:0] d;
        logic b;
        logic [3:0] ev;
        wr = ($urandom % 4) == 0;
        a = 2'($urandom % 4);
        d = 8'($urandom);
        if (a == 2'd0 && ($urandom % 3) != 0) d = KEYV;
        if (a == 2'd1 && ($urandom % 3) != 0) d = 8'h01;
        b = ($urandom % 2) == 0;
        ev = (($urandom % 12) == 0) ? 4'($urandom) : 4'd0;
        step(wr, a, d, b, ev, (b && |ev) ? "R6" : "R2");
      end
    end
    finish_run();
  end
endmodule